// File: doc/BRIEF.md
# UDP Reply Frame Rewriter

This block sits between a cache lookup stage and two egress paths of a network card. It takes in one request frame of exactly 74 bytes. The frame arrives as three beats on a 32-byte stream. A one-bit lookup verdict and a 256-bit cached value come with the first beat. The block holds the whole frame in a single frame buffer before it sends anything out. This is needed because the IPv4 destination address straddles the first beat boundary. Reading that address is the only way to complete the first outgoing beat.

On a cache hit, the block edits the buffered frame in place to turn it into a reply. It swaps the Ethernet addresses, swaps the IPv4 addresses and swaps the UDP ports. It clears the UDP checksum and writes the cached value over the 32-byte key payload. The result goes out on the client-facing port. On a miss, the buffered frame goes to the server-facing port byte for byte. Each port follows its own ready signal. A new request is taken only after the last beat of the current frame has left.

Top module: `udp_reply_rewriter`

## Requirements
- R1: Frame byte b travels in beat b/32, in lane b%32, at bits [8*(b%32)+7 : 8*(b%32)]. A frame is exactly three beats, and bytes 74..95 are filler. rq_ready is high whenever the buffer is empty. It stays low from the acceptance of the third beat until the last outgoing beat is accepted.
- R2: rq_hit and rq_value are sampled only with the first beat of a frame. Their values on the second and third beats have no effect. Hit=1 sends the frame to the client port and hit=0 sends it to the server port. The two valids are never high together.
- R3: On a miss, all 96 byte lanes of the three server beats equal the request beats unchanged.
- R4: On a hit, reply bytes 0..5 carry request bytes 6..11, and reply bytes 6..11 carry request bytes 0..5 (Ethernet destination and source swapped).
- R5: On a hit, reply bytes 26..29 carry request bytes 30..33, and reply bytes 30..33 carry request bytes 26..29 (IPv4 source and destination swapped). This works across the beat boundary.
- R6: On a hit, reply bytes 34..35 carry request bytes 36..37, and reply bytes 36..37 carry request bytes 34..35 (UDP ports swapped).
- R7: On a hit, reply bytes 40..41 (UDP checksum) are zero. Every other header byte passes unchanged, including the IPv4 checksum at bytes 24..25. Filler bytes 74..95 also pass unchanged.
- R8: On a hit, reply byte 42+k equals rq_value[8k+7:8k] for k=0..31. That is lanes 10..31 of beat 1 and lanes 0..9 of beat 2.
- R9: The selected port's valid rises in the cycle right after the third input beat is accepted. The beats go out in order, and last is high on the third beat only.
- R10: While the selected port's valid is high and its ready is low, that port's data and last hold steady. The ready of the port that is not selected has no effect.
- R11: After reset, and again in the cycle after the last outgoing beat is accepted, both valids are low and rq_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Request beat valid |
| rq_ready | output | 1 | Request beat accepted when high with rq_valid |
| rq_data | input | 256 | Request beat, byte lanes little-endian |
| rq_hit | input | 1 | Lookup verdict, sampled with the first beat |
| rq_value | input | 256 | Cached value, sampled with the first beat |
| cl_valid | output | 1 | Client reply beat valid |
| cl_ready | input | 1 | Client port ready |
| cl_data | output | 256 | Client reply beat |
| cl_last | output | 1 | Final reply beat |
| sv_valid | output | 1 | Server forward beat valid |
| sv_ready | input | 1 | Server port ready |
| sv_data | output | 256 | Server forward beat |
| sv_last | output | 1 | Final forward beat |

## Verification
The bench runs 24 frames. Each byte of a frame is an arithmetic function of the frame number and the byte position. No two fields hold the same value, so any wrong swap, a missing beat-crossing byte, or a payload lane that is off by one shows up as a mismatch. The frames mix hits and misses. The bench also drives a changed verdict and value on the second and third beats, which shows whether the verdict is sampled from the first beat only. Each outgoing beat is stalled for a different number of cycles. During stalls the bench toggles the ready of the other port and offers junk requests. This separates correct per-port backpressure from leakage across ports and from early intake of the next frame.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

    localparam int BEAT_BYTES  = 32;
    localparam int DATA_W      = BEAT_BYTES * 8;
    localparam int FRAME_BEATS = 3;
    localparam int FRAME_W     = FRAME_BEATS * DATA_W;
    localparam int BEAT_CW     = $clog2(FRAME_BEATS);
    localparam int VAL_BYTES   = 32;
    localparam int VAL_W       = VAL_BYTES * 8;

    // byte offsets inside the fixed request layout
    localparam int ETH_A_OFS   = 0;
    localparam int ETH_B_OFS   = 6;
    localparam int ETH_LEN     = 6;
    localparam int IP_A_OFS    = 26;
    localparam int IP_B_OFS    = 30;
    localparam int IP_LEN      = 4;
    localparam int PORT_A_OFS  = 34;
    localparam int PORT_B_OFS  = 36;
    localparam int PORT_LEN    = 2;
    localparam int UCSUM_OFS   = 40;
    localparam int UCSUM_LEN   = 2;
    localparam int BODY_OFS    = 42;

    typedef logic [DATA_W-1:0]  beat_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [VAL_W-1:0]   value_t;
    typedef logic [BEAT_CW-1:0] beat_idx_t;

    localparam beat_idx_t LAST_BEAT = beat_idx_t'(FRAME_BEATS - 1);

    typedef struct packed {
        logic   hit;
        value_t value;
    } verdict_t;

    function automatic frame_t swap_span(frame_t f, int a, int b, int len);
        frame_t r;
        r = f;
        for (int k = 0; k < len; k++) begin
            r[8*(a+k) +: 8] = f[8*(b+k) +: 8];
            r[8*(b+k) +: 8] = f[8*(a+k) +: 8];
        end
        return r;
    endfunction

    function automatic frame_t make_reply(frame_t req, value_t val);
        frame_t r;
        r = swap_span(req, ETH_A_OFS, ETH_B_OFS, ETH_LEN);
        r = swap_span(r, IP_A_OFS, IP_B_OFS, IP_LEN);
        r = swap_span(r, PORT_A_OFS, PORT_B_OFS, PORT_LEN);
        for (int k = 0; k < UCSUM_LEN; k++)
            r[8*(UCSUM_OFS+k) +: 8] = 8'h00;
        for (int k = 0; k < VAL_BYTES; k++)
            r[8*(BODY_OFS+k) +: 8] = val[8*k +: 8];
        return r;
    endfunction

endpackage

// File: rtl/rpl_frame_buf.sv
module rpl_frame_buf
    import rpl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    output logic     in_ready,
    input  beat_t    in_data,
    input  verdict_t in_verdict,
    input  logic     release_i,
    output logic     full_o,
    output frame_t   frame_o,
    output verdict_t verdict_o
);

    beat_t     slot_q [FRAME_BEATS];
    beat_idx_t wr_idx;
    logic      full_q;
    verdict_t  vd_q;
    logic      accept;

    assign in_ready  = ~full_q;
    assign accept    = in_valid & ~full_q;
    assign full_o    = full_q;
    assign verdict_o = vd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            full_q <= 1'b0;
            vd_q   <= '0;
        end else if (accept) begin
            if (wr_idx == '0)
                vd_q <= in_verdict;
            if (wr_idx == LAST_BEAT) begin
                wr_idx <= '0;
                full_q <= 1'b1;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end else if (release_i) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept)
            slot_q[wr_idx] <= in_data;
    end

    for (genvar j = 0; j < FRAME_BEATS; j++) begin : g_pack
        assign frame_o[j*DATA_W +: DATA_W] = slot_q[j];
    end

endmodule

// File: rtl/rpl_edit.sv
module rpl_edit
    import rpl_pkg::*;
(
    input  frame_t req_i,
    input  value_t val_i,
    output frame_t rpl_o
);

    assign rpl_o = make_reply(req_i, val_i);

endmodule

// File: rtl/rpl_egress.sv
module rpl_egress
    import rpl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   full_i,
    input  logic   hit_i,
    input  frame_t orig_i,
    input  frame_t edit_i,
    output logic   cl_valid,
    input  logic   cl_ready,
    output beat_t  cl_data,
    output logic   cl_last,
    output logic   sv_valid,
    input  logic   sv_ready,
    output beat_t  sv_data,
    output logic   sv_last,
    output logic   done_o
);

    beat_t     orig_b [FRAME_BEATS];
    beat_t     edit_b [FRAME_BEATS];
    beat_idx_t rd_idx;
    logic      at_last;
    logic      fire;

    for (genvar j = 0; j < FRAME_BEATS; j++) begin : g_unpack
        assign orig_b[j] = orig_i[j*DATA_W +: DATA_W];
        assign edit_b[j] = edit_i[j*DATA_W +: DATA_W];
    end

    assign at_last  = (rd_idx == LAST_BEAT);
    assign cl_valid = full_i & hit_i;
    assign sv_valid = full_i & ~hit_i;
    assign cl_data  = edit_b[rd_idx];
    assign sv_data  = orig_b[rd_idx];
    assign cl_last  = at_last;
    assign sv_last  = at_last;
    assign fire     = (cl_valid & cl_ready) | (sv_valid & sv_ready);
    assign done_o   = fire & at_last;

    always_ff @(posedge clk) begin
        if (rst)
            rd_idx <= '0;
        else if (fire)
            rd_idx <= at_last ? '0 : rd_idx + 1'b1;
    end

endmodule

// File: rtl/udp_reply_rewriter.sv
module udp_reply_rewriter
    import rpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [DATA_W-1:0] rq_data,
    input  logic              rq_hit,
    input  logic [VAL_W-1:0]  rq_value,
    output logic              cl_valid,
    input  logic              cl_ready,
    output logic [DATA_W-1:0] cl_data,
    output logic              cl_last,
    output logic              sv_valid,
    input  logic              sv_ready,
    output logic [DATA_W-1:0] sv_data,
    output logic              sv_last
);

    verdict_t vd_in;
    verdict_t vd_held;
    frame_t   req_frame;
    frame_t   rpl_frame;
    logic     buf_full;
    logic     frame_done;

    assign vd_in.hit   = rq_hit;
    assign vd_in.value = rq_value;

    rpl_frame_buf u_buf (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rq_valid),
        .in_ready   (rq_ready),
        .in_data    (rq_data),
        .in_verdict (vd_in),
        .release_i  (frame_done),
        .full_o     (buf_full),
        .frame_o    (req_frame),
        .verdict_o  (vd_held)
    );

    rpl_edit u_edit (
        .req_i (req_frame),
        .val_i (vd_held.value),
        .rpl_o (rpl_frame)
    );

    rpl_egress u_egr (
        .clk      (clk),
        .rst      (rst),
        .full_i   (buf_full),
        .hit_i    (vd_held.hit),
        .orig_i   (req_frame),
        .edit_i   (rpl_frame),
        .cl_valid (cl_valid),
        .cl_ready (cl_ready),
        .cl_data  (cl_data),
        .cl_last  (cl_last),
        .sv_valid (sv_valid),
        .sv_ready (sv_ready),
        .sv_data  (sv_data),
        .sv_last  (sv_last),
        .done_o   (frame_done)
    );

endmodule

// File: rtl/rpl_checker.sv
module rpl_checker
    import rpl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rq_valid,
    input logic              rq_ready,
    input logic              rq_hit,
    input logic              cl_valid,
    input logic              cl_ready,
    input logic [DATA_W-1:0] cl_data,
    input logic              cl_last,
    input logic              sv_valid,
    input logic              sv_ready,
    input logic [DATA_W-1:0] sv_data,
    input logic              sv_last
);

    logic [1:0] in_cnt;
    logic       hit_seen;
    logic       take;

    assign take = rq_valid & rq_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt   <= '0;
            hit_seen <= 1'b0;
        end else if (take) begin
            if (in_cnt == 2'd0)
                hit_seen <= rq_hit;
            in_cnt <= (in_cnt == 2'd2) ? 2'd0 : in_cnt + 2'd1;
        end
    end

    assert_one_port_R2: assert property (@(posedge clk) disable iff (rst)
        !(cl_valid && sv_valid));

    assert_route_R2: assert property (@(posedge clk) disable iff (rst)
        (take && in_cnt == 2'd2) |=> (cl_valid == hit_seen));

    assert_no_intake_R1: assert property (@(posedge clk) disable iff (rst)
        (cl_valid || sv_valid) |-> !rq_ready);

    assert_launch_R9: assert property (@(posedge clk) disable iff (rst)
        (take && in_cnt == 2'd2) |=> ((cl_valid || sv_valid) && !cl_last && !sv_last));

    assert_hold_cl_R10: assert property (@(posedge clk) disable iff (rst)
        (cl_valid && !cl_ready) |=> (cl_valid && $stable(cl_data) && $stable(cl_last)));

    assert_hold_sv_R10: assert property (@(posedge clk) disable iff (rst)
        (sv_valid && !sv_ready) |=> (sv_valid && $stable(sv_data) && $stable(sv_last)));

    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        ((cl_valid && cl_ready && cl_last) || (sv_valid && sv_ready && sv_last))
        |=> (rq_ready && !cl_valid && !sv_valid));

endmodule

bind udp_reply_rewriter rpl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rq_hit   (rq_hit),
    .cl_valid (cl_valid),
    .cl_ready (cl_ready),
    .cl_data  (cl_data),
    .cl_last  (cl_last),
    .sv_valid (sv_valid),
    .sv_ready (sv_ready),
    .sv_data  (sv_data),
    .sv_last  (sv_last)
);

// File: tb/sim_udp_reply_rewriter.sv
module sim_udp_reply_rewriter;

    logic         clk = 1'b0;
    logic         rst;
    logic         rq_valid;
    logic         rq_ready;
    logic [255:0] rq_data;
    logic         rq_hit;
    logic [255:0] rq_value;
    logic         cl_valid;
    logic         cl_ready;
    logic [255:0] cl_data;
    logic         cl_last;
    logic         sv_valid;
    logic         sv_ready;
    logic [255:0] sv_data;
    logic         sv_last;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    udp_reply_rewriter u0 (
        .clk(clk), .rst(rst),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_data(rq_data),
        .rq_hit(rq_hit), .rq_value(rq_value),
        .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_data(cl_data), .cl_last(cl_last),
        .sv_valid(sv_valid), .sv_ready(sv_ready), .sv_data(sv_data), .sv_last(sv_last)
    );

    function automatic logic [7:0] fb(int n, int b);
        return 8'((n * 37 + b * 11 + 5) % 256);
    endfunction

    function automatic logic [7:0] vb(int n, int k);
        return 8'((n * 53 + k * 7 + 1) % 256);
    endfunction

    function automatic logic [7:0] exp_byte(int n, int b, bit hit);
        if (!hit)             return fb(n, b);
        if (b < 6)            return fb(n, b + 6);
        if (b < 12)           return fb(n, b - 6);
        if (b >= 26 && b < 30) return fb(n, b + 4);
        if (b >= 30 && b < 34) return fb(n, b - 4);
        if (b == 34 || b == 35) return fb(n, b + 2);
        if (b == 36 || b == 37) return fb(n, b - 2);
        if (b == 40 || b == 41) return 8'h00;
        if (b >= 42 && b < 74) return vb(n, b - 42);
        return fb(n, b);
    endfunction

    function automatic logic [255:0] in_beat(int n, int j);
        logic [255:0] r;
        for (int k = 0; k < 32; k++) r[8*k +: 8] = fb(n, j * 32 + k);
        return r;
    endfunction

    function automatic logic [255:0] exp_beat(int n, int j, bit hit);
        logic [255:0] r;
        for (int k = 0; k < 32; k++) r[8*k +: 8] = exp_byte(n, j * 32 + k, hit);
        return r;
    endfunction

    function automatic logic [255:0] val_word(int n);
        logic [255:0] r;
        for (int k = 0; k < 32; k++) r[8*k +: 8] = vb(n, k);
        return r;
    endfunction

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_beat(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_frame(int n, bit hit);
        for (int j = 0; j < 3; j++) begin
            rq_valid = 1'b1;
            rq_data  = in_beat(n, j);
            // only the first beat carries the real verdict (R2)
            rq_hit   = (j == 0) ? hit : ~hit;
            rq_value = (j == 0) ? val_word(n) : ~val_word(n);
            while (!rq_ready) @(negedge clk);
            @(negedge clk);
        end
        rq_valid = 1'b0;
    endtask

    task automatic recv_frame(int n, bit hit);
        string tag;
        tag = hit ? "R4 R5 R6 R7 R8 reply beat" : "R3 forward beat";
        for (int j = 0; j < 3; j++) begin
            for (int s = 0; s < (n + j) % 3; s++) begin
                if (hit) begin cl_ready = 1'b0; sv_ready = 1'b1; end
                else     begin sv_ready = 1'b0; cl_ready = 1'b1; end
                rq_valid = 1'b1;
                rq_data  = ~in_beat(n, j);
                rq_hit   = s[0];
                @(negedge clk);
                chk_bit("R10 valid held", hit ? cl_valid : sv_valid, 1'b1);
                chk_beat("R10 data held", hit ? cl_data : sv_data, exp_beat(n, j, hit));
                chk_bit("R1 no intake while sending", rq_ready, 1'b0);
            end
            cl_ready = hit ? 1'b1 : j[0];
            sv_ready = hit ? j[0] : 1'b1;
            chk_bit("R2 port select", hit ? cl_valid : sv_valid, 1'b1);
            chk_bit("R2 other port idle", hit ? sv_valid : cl_valid, 1'b0);
            chk_beat(tag, hit ? cl_data : sv_data, exp_beat(n, j, hit));
            chk_bit("R9 last flag", hit ? cl_last : sv_last, (j == 2));
            @(negedge clk);
        end
        rq_valid = 1'b0;
        cl_ready = 1'b0;
        sv_ready = 1'b0;
        chk_bit("R11 intake reopened", rq_ready, 1'b1);
        chk_bit("R11 client idle", cl_valid, 1'b0);
        chk_bit("R11 server idle", sv_valid, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        rq_valid = 1'b0;
        rq_data  = '0;
        rq_hit   = 1'b0;
        rq_value = '0;
        cl_ready = 1'b0;
        sv_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_bit("R11 reset ready", rq_ready, 1'b1);
        chk_bit("R11 reset client", cl_valid, 1'b0);
        chk_bit("R11 reset server", sv_valid, 1'b0);

        for (int n = 0; n < 24; n++) begin
            bit hit;
            hit = (n % 3 != 1);
            send_frame(n, hit);
            // third beat accepted on the edge just passed (R9)
            chk_bit("R9 output next cycle", hit ? cl_valid : sv_valid, 1'b1);
            chk_bit("R1 buffer closed", rq_ready, 1'b0);
            recv_frame(n, hit);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule